// File: doc/BRIEF.md
# I2C Arbitration-Loss Recovery Monitor

This block sits next to an I2C master controller and watches for one silent failure. Sometimes software asks for a start while another master already holds the bus, and no start condition was ever seen on the wires. In that case the master reports arbitration lost, but the bus-busy flag stays low. Because no transfer ever reaches its acknowledge clock, no byte-complete interrupt is raised, and software can wait forever.

The monitor samples SCL and SDA through synchronizers and tracks bus ownership from start and stop conditions. When software issues a start request while the interface is enabled, the monitor runs a window of three bit periods at the programmed bus rate. At 100 kHz this is 30 µs. When the window ends, the monitor checks the arbitration-lost input and the busy flag:

- If arbitration was lost while the bus still looks idle, it pulses a forced enable-clear to reinitialize the master. It also sets a sticky recovery flag and an interrupt.
- For any other combination, normal processing is left alone.

Top module: `arb_recover_mon`

## Requirements
- R1: After reset, `en_clear`, `rec_flag`, `rec_irq` and `bus_busy` are all 0.
- R2: An SDA fall while SCL is high (start condition) sets `bus_busy`, and an SDA rise while SCL is high (stop condition) clears it. The flag changes on the third rising clock edge after the pin change.
- R3: A start request is accepted only when `start_req` and `en_in` are both 1 on the same edge and the monitor is not locked (see R9). A request made while `en_in` is 0 leads to no recovery.
- R4: The window ends 3×`bit_period` clocks after the edge that accepted the request. A `bit_period` of 0 is treated as 1. If `arb_lost` is 1 and `bus_busy` is 0 in the last cycle of the window, `en_clear` is high for exactly one clock, starting at the edge that closes the window.
- R5: If `arb_lost` is 0 when the window ends, `en_clear` stays low and `rec_flag` stays unchanged.
- R6: If `bus_busy` is 1 in any cycle of a running window, the window is cancelled and no recovery follows.
- R7: A recovery sets `rec_flag` and `rec_irq` at the same edge as `en_clear`. Both stay at 1 until `clr_flag` is sampled high, which clears them at that edge.
- R8: If a recovery and a `clr_flag` write fall on the same edge, the recovery wins and both flags read 1 afterwards.
- R9: After a recovery, start requests are ignored until `en_in` is seen going from 0 to 1.
- R10: A start request accepted while a window is running restarts the window. The full 3×`bit_period` count begins again from the new accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| en_in | input | 1 | Interface enable bit as currently set by software |
| start_req | input | 1 | One-cycle strobe: software asks the master for a start |
| arb_lost | input | 1 | Arbitration-lost status from the master |
| bit_period | input | PW (16) | Bus bit period in system clocks |
| clr_flag | input | 1 | One-cycle software write that clears the recovery flag |
| en_clear | output | 1 | One-cycle pulse that forces the interface enable low |
| rec_flag | output | 1 | Sticky recovery-taken flag |
| rec_irq | output | 1 | Recovery interrupt request |
| bus_busy | output | 1 | Bus occupied, between a start and a stop condition |

## Verification
Two pairs of events can land on the same clock edge, and each is tested directly.

- **Recovery set against software clear.** The bench drives `clr_flag` so it is sampled on exactly the edge that closes a window with arbitration lost. The result is judged correct only if both `rec_flag` and `rec_irq` read 1 afterwards.
- **Busy rise against window end.** The bench pulls SDA low under a high SCL inside the window, so that `bus_busy` rises before the window would expire. The check expects no `en_clear` pulse at the expiry cycle.

Random trials mix these cases with random bit periods and random arbitration-lost levels.

// File: rtl/arm_pkg.sv
// Package: shared types and defaults for the arbitration-loss recovery monitor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package arm_pkg;
    // State of the post-request timing window.
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_t;

    // Bus events decoded from the synchronized lines.
    typedef struct packed {
        logic start_seen;
        logic stop_seen;
    } bus_evt_t;

    // Bit periods in one check window.
    localparam int unsigned WIN_BITS = 3;
endpackage

// File: rtl/arm_sync.sv
// Module: arm_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: the idle level of each line is 1 (I2C pull-ups), so every stage resets to 1.
module arm_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture stage of the asynchronous lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Further stage that settles metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/arm_bus_watch.sv
// Module: arm_bus_watch
// Decodes start and stop conditions from synchronized SCL/SDA and holds the bus-busy flag.
// Assumes: inputs are already synchronized to clk and idle high after reset.
module arm_bus_watch
    import arm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt,
    output logic     busy
);
    logic sda_d;

    // Remember the previous SDA level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_d <= 1'b1;
        else        sda_d <= sda_s;
    end

    // A start is SDA falling with SCL high; a stop is SDA rising with SCL high.
    always_comb begin
        evt.start_seen = scl_s &  sda_d & ~sda_s;
        evt.stop_seen  = scl_s & ~sda_d &  sda_s;
    end

    // Bus ownership: set on a start, cleared on a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)              busy <= 1'b0;
        else if (evt.start_seen) busy <= 1'b1;
        else if (evt.stop_seen)  busy <= 1'b0;
    end
endmodule

// File: rtl/arm_window.sv
// Module: arm_window
// Down-counter that times the check window after an accepted start request.
// Assumes: load_val is at least 1. A load while running restarts the count.
// The cancel input ends the window with no expiry.
module arm_window
    import arm_pkg::*;
#(
    parameter int unsigned CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          cancel,
    output logic          expire,
    output logic          running
);
    win_state_t    st_q;
    logic [CW-1:0] cnt_q;
    logic          last_cyc;

    assign last_cyc = (cnt_q == CW'(1));
    assign running  = (st_q == WIN_RUN);
    // The window closes only if it is neither restarted nor cancelled in its last cycle.
    assign expire   = running & last_cyc & ~load & ~cancel;

    // Window state and count: load wins, then cancel, then the final cycle, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WIN_IDLE;
            cnt_q <= '0;
        end else if (load) begin
            st_q  <= WIN_RUN;
            cnt_q <= load_val;
        end else if (running) begin
            if (cancel || last_cyc) begin
                st_q <= WIN_IDLE;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end
endmodule

// File: rtl/arm_recover.sv
// Module: arm_recover
// Decides on recovery at window expiry, holds the sticky flag and interrupt,
// and locks out start requests until software enables the interface again.
// Assumes: arb_lost and en_in are synchronous to clk.
module arm_recover (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    input  logic start_req,
    input  logic arb_lost,
    input  logic expire,
    input  logic clr_flag,
    output logic accept,
    output logic en_clear,
    output logic rec_flag,
    output logic rec_irq
);
    logic locked_q;
    logic en_d;
    logic fire;
    logic en_rise;

    assign fire    = expire & arb_lost;
    assign en_rise = en_in & ~en_d;
    assign accept  = start_req & en_in & ~locked_q;

    // Previous enable level, used to see software re-enabling the interface.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= en_in;
    end

    // One-cycle forced enable-clear when the failure combination is found.
    always_ff @(posedge clk) begin
        if (!rst_n) en_clear <= 1'b0;
        else        en_clear <= fire;
    end

    // Sticky recovery flag: a recovery beats a software clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        rec_flag <= 1'b0;
        else if (fire)     rec_flag <= 1'b1;
        else if (clr_flag) rec_flag <= 1'b0;
    end

    // Interrupt line: same set and clear rules as the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        rec_irq <= 1'b0;
        else if (fire)     rec_irq <= 1'b1;
        else if (clr_flag) rec_irq <= 1'b0;
    end

    // Start lockout after recovery, released by a rising enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (fire)    locked_q <= 1'b1;
        else if (en_rise) locked_q <= 1'b0;
    end
endmodule

// File: rtl/arb_recover_mon.sv
// Module: arb_recover_mon (top)
// Watches an I2C bus and a master's status. After a start request it times
// WIN_BITS bit periods, then forces a reinitialization if arbitration was
// lost while the bus still looked idle.
// Assumes: bit_period is in system clocks and is held stable during a window.
module arb_recover_mon
    import arm_pkg::*;
#(
    parameter int unsigned PW          = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          en_in,
    input  logic          start_req,
    input  logic          arb_lost,
    input  logic [PW-1:0] bit_period,
    input  logic          clr_flag,
    output logic          en_clear,
    output logic          rec_flag,
    output logic          rec_irq,
    output logic          bus_busy
);
    localparam int unsigned CW = PW + $clog2(WIN_BITS + 1);

    logic [1:0]    lines_s;
    bus_evt_t      evt;
    logic          accept;
    logic          expire;
    logic          running;
    logic [CW-1:0] period_eff;
    logic [CW-1:0] win_len;

    // Window length: WIN_BITS times the bit period, with a zero period taken as one.
    always_comb begin
        period_eff = (bit_period == '0) ? CW'(1) : CW'(bit_period);
        win_len    = CW'(period_eff * CW'(WIN_BITS));
    end

    arm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (lines_s)
    );

    arm_bus_watch u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .evt   (evt),
        .busy  (bus_busy)
    );

    arm_window #(.CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (win_len),
        .cancel   (bus_busy),
        .expire   (expire),
        .running  (running)
    );

    arm_recover u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_in     (en_in),
        .start_req (start_req),
        .arb_lost  (arb_lost),
        .expire    (expire),
        .clr_flag  (clr_flag),
        .accept    (accept),
        .en_clear  (en_clear),
        .rec_flag  (rec_flag),
        .rec_irq   (rec_irq)
    );
endmodule

// File: rtl/arm_checker.sv
// Module: arm_checker
// Temporal properties on the monitor's ports, bound to arb_recover_mon.
module arm_checker (
    input logic clk,
    input logic rst_n,
    input logic arb_lost,
    input logic clr_flag,
    input logic en_clear,
    input logic rec_flag,
    input logic rec_irq,
    input logic bus_busy
);
    // R4: the forced enable-clear lasts exactly one clock.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        en_clear |=> !en_clear);

    // R4 / R5 / R6: a recovery follows only from arbitration lost on an idle bus.
    a_r4_needs_al_idle: assert property (@(posedge clk) disable iff (!rst_n)
        en_clear |-> ($past(arb_lost) && !$past(bus_busy)));

    // R7: the flag holds until a clear write.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_flag && !clr_flag) |=> rec_flag);

    // R7: the flag only rises together with a forced enable-clear.
    a_r7_rise_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_flag) |-> en_clear);

    // R8: a recovery leaves both flag and interrupt set even with a clear write.
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        en_clear |-> (rec_flag && rec_irq));
endmodule

bind arb_recover_mon arm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb_lost (arb_lost),
    .clr_flag (clr_flag),
    .en_clear (en_clear),
    .rec_flag (rec_flag),
    .rec_irq  (rec_irq),
    .bus_busy (bus_busy)
);

// File: tb/sim_arb_recover_mon.sv
module sim_arb_recover_mon;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_in = 1'b1;
    logic          sda_in = 1'b1;
    logic          en_in = 1'b1;
    logic          start_req = 1'b0;
    logic          arb_lost = 1'b0;
    logic [PW-1:0] bit_period = 16'd2;
    logic          clr_flag = 1'b0;
    logic          en_clear, rec_flag, rec_irq, bus_busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    arb_recover_mon #(.PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .en_in(en_in), .start_req(start_req), .arb_lost(arb_lost),
        .bit_period(bit_period), .clr_flag(clr_flag),
        .en_clear(en_clear), .rec_flag(rec_flag), .rec_irq(rec_irq),
        .bus_busy(bus_busy)
    );

    // Window length in clocks, computed from the requirement (R4).
    function automatic int win_cycles(input int p);
        return 3 * ((p == 0) ? 1 : p);
    endfunction

    // Expected recovery decision at window end (R4, R5, R6).
    function automatic bit exp_recover(input bit al, input bit busy_in_window);
        return al && !busy_in_window;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe start_req for one edge; returns at the negedge after the accepting edge.
    task automatic pulse_start(input bit drop_sda);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        if (drop_sda) sda_in = 1'b0;
    endtask

    // Software re-enables the interface and clears the flag (R9, R7).
    task automatic sw_restore();
        en_in = 1'b0; tick(1);
        en_in = 1'b1; tick(1);
        clr_flag = 1'b1; tick(1);
        clr_flag = 1'b0;
        chk("R7 flag cleared", rec_flag, 0);
        chk("R7 irq cleared", rec_irq, 0);
    endtask

    task automatic trial(input int p, input bit al, input bit inject);
        bit expv;
        int w;
        w = win_cycles(p);
        bit_period = PW'(p);
        arb_lost = al;
        pulse_start(inject);
        tick(w - 1);
        chk("R4 no pulse before window end", en_clear, 0);
        tick(1);
        expv = exp_recover(al, inject);
        chk(inject ? "R6 busy cancels" : (al ? "R4 recovery pulse" : "R5 no arb loss"),
            en_clear, int'(expv));
        chk("R7 flag after window", rec_flag, int'(expv));
        chk("R7 irq after window", rec_irq, int'(expv));
        if (inject) begin
            sda_in = 1'b1;
            tick(4);
            chk("R2 stop clears busy", bus_busy, 0);
        end
        if (expv) begin
            arb_lost = 1'b1;
            pulse_start(1'b0);
            tick(w);
            chk("R9 start ignored while locked", en_clear, 0);
            sw_restore();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 en_clear reset", en_clear, 0);
        chk("R1 rec_flag reset", rec_flag, 0);
        chk("R1 rec_irq reset", rec_irq, 0);
        chk("R1 bus_busy reset", bus_busy, 0);

        // R2: start then stop, with three-edge latency.
        sda_in = 1'b0;
        tick(2); chk("R2 busy not yet", bus_busy, 0);
        tick(1); chk("R2 busy after start", bus_busy, 1);
        sda_in = 1'b1;
        tick(2); chk("R2 busy holds", bus_busy, 1);
        tick(1); chk("R2 busy after stop", bus_busy, 0);

        // R3: request while disabled is not accepted.
        en_in = 1'b0; arb_lost = 1'b1; bit_period = 16'd2;
        pulse_start(1'b0);
        tick(win_cycles(2) + 2);
        chk("R3 disabled start ignored", rec_flag, 0);
        en_in = 1'b1; tick(1);

        // R4: zero period behaves as one (window of 3).
        trial(0, 1'b1, 1'b0);

        // R10: a second request restarts the window.
        bit_period = 16'd3; arb_lost = 1'b1;
        pulse_start(1'b0);
        tick(4);
        pulse_start(1'b0);
        tick(4); chk("R10 old expiry suppressed", en_clear, 0);
        tick(4); chk("R10 before new expiry", en_clear, 0);
        tick(1); chk("R10 restarted window fires", en_clear, 1);
        sw_restore();

        // R8: clear write lands on the recovery edge.
        bit_period = 16'd2; arb_lost = 1'b1;
        pulse_start(1'b0);
        tick(win_cycles(2) - 1);
        clr_flag = 1'b1;
        tick(1);
        clr_flag = 1'b0;
        chk("R8 pulse with clear", en_clear, 1);
        chk("R8 flag wins", rec_flag, 1);
        chk("R8 irq wins", rec_irq, 1);
        tick(2);
        chk("R7 flag sticky", rec_flag, 1);
        sw_restore();

        // Random mix of periods, arbitration outcome and bus activity.
        for (int i = 0; i < 40; i++) begin
            int p;
            p = 2 + int'($urandom_range(7));
            trial(p, 1'($urandom_range(1)), ($urandom_range(2) == 0));
            tick(2);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule